// File: doc/BRIEF.md
# Reference Frame Read Cache

This block sits in front of a slow burst-oriented frame memory and serves single-sample reads from a motion-compensation address generator. Each request names one sample by address. When the line holding that sample is resident, the request is accepted at once and the sample appears on the response port one clock later. When it is not resident, the cache asks the memory for the whole line. It then stalls the request until the burst has been written into local storage, and finally serves the same request as a hit.

The cache is direct mapped. The memory side is a one-cycle request pulse carrying the line's base address, followed later by a run of data beats. Each beat carries several samples. The memory decides how long its setup phase lasts. The cache only counts beats, so a memory with a fixed setup delay followed by a contiguous burst gives a fixed miss penalty. Two saturating counters, one for accepted requests and one for misses, let the miss rate of an access pattern be measured. A control pulse clears them. A flush input drops every resident line, for example at the start of a frame.

Top module: `ref_line_cache`

## Requirements
- R1: After reset no line is resident, `rspValid` and `memReqValid` are low, and both counters read zero.
- R2: An address is split into three fields. The offset is the low log2(LINE_SAMPLES) bits, the line index is the next log2(NUM_LINES) bits, and the tag is the remaining upper bits. Each index holds exactly one line, so a request whose tag differs from the one resident at its index misses and replaces that line. A request for a different index leaves that line untouched. `memReqAddr` is the request address with the offset bits zeroed.
- R3: A valid request to a non-resident line raises `memReqValid` for exactly one cycle, in that same cycle, and the request is not accepted. `reqReady` stays low for the whole fill.
- R4: A fill takes LINE_SAMPLES/BEAT_SAMPLES beats. In each beat, sample k of the beat sits in `memData` bits [k*SAMPLE_W +: SAMPLE_W], and beat j holds line offsets j*BEAT_SAMPLES to j*BEAT_SAMPLES+BEAT_SAMPLES-1. With a memory that starts its beats 10 clock edges after the request edge and sends 8 beats back to back, a missing request is accepted on the 19th clock edge counted from its miss edge (an 18-cycle penalty).
- R5: When the addressed line is resident and no fill is running, `reqReady` is high in the same cycle. An accepted request raises `rspValid` for one cycle on the next cycle, with the addressed sample on `rspData`. Back-to-back hits are accepted every cycle.
- R6: A request stalled by a miss is held by the requester. It is accepted as a hit in the cycle after the last beat, and it returns the freshly filled sample.
- R7: A `flush` pulse makes every line non-resident, so the next request to any previously resident line misses.
- R8: `accessCount` increments once for each accepted request. `missCount` increments once in each cycle that starts a fill.
- R9: Both counters stop at their all-ones value. A `statClear` pulse sets both counters to zero, and it takes priority over an increment in the same cycle.
- R10: Data beats that arrive while no fill is running are ignored. Resident data is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| statClear | input | 1 | Zero both counters |
| reqValid | input | 1 | Sample request present |
| reqAddr | input | ADDR_W | Sample address |
| reqReady | output | 1 | Request accepted this cycle |
| rspValid | output | 1 | Response sample valid |
| rspData | output | SAMPLE_W | Response sample |
| memReqValid | output | 1 | One-cycle line fetch request |
| memReqAddr | output | ADDR_W | Base address of the line to fetch |
| memDataValid | input | 1 | Data beat present |
| memData | input | BEAT_SAMPLES*SAMPLE_W | Data beat, sample 0 in the low bits |
| accessCount | output | CNT_W | Accepted requests, saturating |
| missCount | output | CNT_W | Fills started, saturating |

## Verification
The assertions rely on several properties of the environment. The requester holds `reqAddr` steady while a request waits. `flush` is never pulsed in the same cycle that a fill completes. The memory sends exactly one line's worth of beats after each request. The stimulus drives requests through a task that keeps the address fixed until acceptance. It flushes only between requests. It models a memory with a 10-edge setup followed by a contiguous 8-beat burst. Stray beats are injected only while the cache is idle, and this exercises R10.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } rfcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // request accepted as a hit
    logic miss;      // fill starts this cycle
    logic beatWr;    // write one beat into the fill line
    logic fillDone;  // last beat written, line becomes resident
  } rfcStrobe_t;

endpackage

// File: rtl/rfc_sat_counter.sv
module rfc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rstN || clr) cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + 1'b1;
  end

  AST_CNT_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '1 && !clr) |=> cnt == '1); // R9
  AST_CNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> cnt >= $past(cnt)); // R9

endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
#(
  parameter int BEATS      = 8,
  parameter int BEAT_IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  hit,
  input  logic                  memDataValid,
  output logic                  reqReady,
  output logic                  memReqValid,
  output rfcStrobe_t            strobe,
  output logic [BEAT_IDX_W-1:0] beatIdx
);

  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(BEATS - 1);

  rfcState_e             state;
  logic [BEAT_IDX_W-1:0] beatCnt;

  always_comb begin
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    if (state == ST_IDLE) begin
      reqReady      = hit;
      strobe.accept = reqValid && hit;
      strobe.miss   = reqValid && !hit;
      memReqValid   = reqValid && !hit;
    end else begin
      strobe.beatWr   = memDataValid;
      strobe.fillDone = memDataValid && (beatCnt == LAST_BEAT);
    end
  end

  assign beatIdx = beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      if (strobe.miss) state <= ST_FILL;
      else if (strobe.fillDone) state <= ST_IDLE;
      if (strobe.fillDone) beatCnt <= '0;
      else if (strobe.beatWr) beatCnt <= beatCnt + 1'b1;
    end
  end

  AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FILL |-> !reqReady); // R3
  AST_MEMREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R3
  AST_FILL_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillDone |=> (state == ST_IDLE && beatCnt == '0)); // R4

endmodule

// File: rtl/rfc_datapath.sv
module rfc_datapath
  import rfc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SAMPLE_W     = 8,
  parameter int NUM_LINES    = 16,
  parameter int LINE_SAMPLES = 32,
  parameter int BEAT_SAMPLES = 4,
  parameter int CNT_W        = 32,
  parameter int BEAT_IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             flush,
  input  logic                             statClear,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  rfcStrobe_t                       strobe,
  input  logic [BEAT_IDX_W-1:0]            beatIdx,
  input  logic [BEAT_SAMPLES*SAMPLE_W-1:0] memData,
  output logic                             hit,
  output logic [ADDR_W-1:0]                memReqAddr,
  output logic                             rspValid,
  output logic [SAMPLE_W-1:0]              rspData,
  output logic [CNT_W-1:0]                 accessCount,
  output logic [CNT_W-1:0]                 missCount
);

  localparam int OFF_W  = $clog2(LINE_SAMPLES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BEAT_W = BEAT_SAMPLES * SAMPLE_W;
  localparam int LINE_W = LINE_SAMPLES * SAMPLE_W;

  logic [NUM_LINES-1:0] validQ;
  logic [TAG_W-1:0]     tagQ    [NUM_LINES];
  logic [LINE_W-1:0]    lineMem [NUM_LINES];
  logic [IDX_W-1:0]     fillIdx;
  logic [TAG_W-1:0]     fillTag;

  logic [OFF_W-1:0] lkOff;
  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;

  assign lkOff      = reqAddr[OFF_W-1:0];
  assign lkIdx      = reqAddr[OFF_W +: IDX_W];
  assign lkTag      = reqAddr[ADDR_W-1 -: TAG_W];
  assign hit        = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign memReqAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // residency: flush clears everything, a completing fill re-marks its line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      if (flush) validQ <= '0;
      if (strobe.fillDone) validQ[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.miss) begin
      fillIdx <= lkIdx;
      fillTag <= lkTag;
    end
    if (strobe.fillDone) tagQ[fillIdx] <= fillTag;
    if (strobe.beatWr) lineMem[fillIdx][beatIdx*BEAT_W +: BEAT_W] <= memData;
    if (strobe.accept) rspData <= lineMem[lkIdx][lkOff*SAMPLE_W +: SAMPLE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else rspValid <= strobe.accept;
  end

  logic [1:0] cntInc;
  logic [CNT_W-1:0] cntVal [2];
  assign cntInc = {strobe.miss, strobe.accept};

  for (genvar c = 0; c < 2; c++) begin : g_stat
    rfc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (statClear),
      .inc  (cntInc[c]),
      .cnt  (cntVal[c])
    );
  end

  assign accessCount = cntVal[0];
  assign missCount   = cntVal[1];

  AST_FILL_MAKES_RESIDENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillDone && !flush) |=> validQ[$past(fillIdx)]); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !strobe.fillDone) |=> validQ == '0); // R7
  AST_ACCEPT_IS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> hit); // R5

endmodule

// File: rtl/ref_line_cache.sv
module ref_line_cache
  import rfc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SAMPLE_W     = 8,
  parameter int NUM_LINES    = 16,
  parameter int LINE_SAMPLES = 32,
  parameter int BEAT_SAMPLES = 4,
  parameter int CNT_W        = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             flush,
  input  logic                             statClear,
  input  logic                             reqValid,
  input  logic [ADDR_W-1:0]                reqAddr,
  output logic                             reqReady,
  output logic                             rspValid,
  output logic [SAMPLE_W-1:0]              rspData,
  output logic                             memReqValid,
  output logic [ADDR_W-1:0]                memReqAddr,
  input  logic                             memDataValid,
  input  logic [BEAT_SAMPLES*SAMPLE_W-1:0] memData,
  output logic [CNT_W-1:0]                 accessCount,
  output logic [CNT_W-1:0]                 missCount
);

  localparam int BEATS      = LINE_SAMPLES / BEAT_SAMPLES;
  localparam int BEAT_IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  rfcStrobe_t            strobe;
  logic [BEAT_IDX_W-1:0] beatIdx;
  logic                  hit;

  rfc_ctrl #(
    .BEATS      (BEATS),
    .BEAT_IDX_W (BEAT_IDX_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .hit          (hit),
    .memDataValid (memDataValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .strobe       (strobe),
    .beatIdx      (beatIdx)
  );

  rfc_datapath #(
    .ADDR_W       (ADDR_W),
    .SAMPLE_W     (SAMPLE_W),
    .NUM_LINES    (NUM_LINES),
    .LINE_SAMPLES (LINE_SAMPLES),
    .BEAT_SAMPLES (BEAT_SAMPLES),
    .CNT_W        (CNT_W),
    .BEAT_IDX_W   (BEAT_IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .statClear   (statClear),
    .reqAddr     (reqAddr),
    .strobe      (strobe),
    .beatIdx     (beatIdx),
    .memData     (memData),
    .hit         (hit),
    .memReqAddr  (memReqAddr),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .accessCount (accessCount),
    .missCount   (missCount)
  );

endmodule

// File: tb/tb_ref_line_cache.sv
`timescale 1ns/100ps
module tb_ref_line_cache;

  localparam int AW = 16, SW = 8, NL = 16, LS = 32, BS = 4, CW = 8;
  localparam int SETUP = 10, BEATS = LS / BS;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, statClear = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, rspValid, memReqValid;
  logic [SW-1:0] rspData;
  logic [AW-1:0] memReqAddr;
  logic memDataValid = 1'b0;
  logic [BS*SW-1:0] memData = '0;
  logic [CW-1:0] accessCount, missCount;

  always #2.5 clk = ~clk;

  ref_line_cache #(.ADDR_W(AW), .SAMPLE_W(SW), .NUM_LINES(NL),
    .LINE_SAMPLES(LS), .BEAT_SAMPLES(BS), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .statClear(statClear),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memDataValid(memDataValid), .memData(memData),
    .accessCount(accessCount), .missCount(missCount));

  int nChecks = 0, nFail = 0;
  bit junk = 1'b0;

  function automatic logic [SW-1:0] sampleAt(int a);
    return SW'((a * 37) ^ (a >> 5) ^ 8'h5A);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model state
  bit mValid[NL];
  int mBase[NL];
  bit mFill, mRspV;
  int mBeats, mFillBase, mRspD, mAcc, mMiss;
  int pend, memBase;

  // memory: beats on edges SETUP..SETUP+BEATS-1 after the request edge
  always @(negedge clk) begin
    if (pend >= SETUP && pend < SETUP + BEATS) begin
      memDataValid = 1'b1;
      for (int k = 0; k < BS; k++)
        memData[k*SW +: SW] = sampleAt(memBase + (pend - SETUP) * BS + k);
    end else if (junk) begin
      memDataValid = 1'b1;
      memData = 32'hA5C3_3CA5;
    end else begin
      memDataValid = 1'b0;
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rstN) begin
      for (int i = 0; i < NL; i++) mValid[i] = 1'b0;
      mFill = 0; mRspV = 0; mBeats = 0; mAcc = 0; mMiss = 0; pend = 0;
    end else begin
      int a, base, idx;
      bit mHit, expReady, expMem;
      a = int'(reqAddr);
      base = a & ~(LS - 1);
      idx = (a / LS) % NL;
      mHit = mValid[idx] && mBase[idx] == base;
      expReady = !mFill && mHit;
      expMem = reqValid && !mFill && !mHit;
      chk(reqReady == expReady, "R5 reqReady", reqReady, expReady);
      chk(memReqValid == expMem, "R3 memReqValid", memReqValid, expMem);
      if (expMem) chk(int'(memReqAddr) == base, "R2 memReqAddr", memReqAddr, base);
      chk(rspValid == mRspV, "R5 rspValid", rspValid, mRspV);
      if (mRspV) chk(int'(rspData) == mRspD, "R5 rspData", rspData, mRspD);
      chk(int'(accessCount) == mAcc, "R8 accessCount", accessCount, mAcc);
      chk(int'(missCount) == mMiss, "R8 missCount", missCount, mMiss);
      // advance model across the coming edge
      mRspV = reqValid && expReady;
      if (mRspV) begin
        mRspD = int'(sampleAt(a));
        if (mAcc < MAXC) mAcc++;
      end
      if (expMem) begin
        mFill = 1; mBeats = 0; mFillBase = base;
        if (mMiss < MAXC) mMiss++;
      end else if (mFill && memDataValid) begin
        mBeats++;
      end
      if (statClear) begin mAcc = 0; mMiss = 0; end
      if (flush) for (int i = 0; i < NL; i++) mValid[i] = 1'b0;
      if (mFill && mBeats == BEATS) begin
        mValid[(mFillBase / LS) % NL] = 1'b1;
        mBase[(mFillBase / LS) % NL] = mFillBase;
        mFill = 0;
      end
      if (memReqValid) begin pend = 1; memBase = int'(memReqAddr); end
      else if (pend > 0) pend = (pend == SETUP + BEATS - 1) ? 0 : pend + 1;
    end
  end

  // drive one request; returns the number of edges until acceptance
  task automatic doAccess(input int a, output int edges);
    bit ok;
    reqValid = 1'b1;
    reqAddr = AW'(a);
    edges = 0;
    do begin
      #2;
      ok = reqReady;
      @(negedge clk);
      edges++;
    end while (!ok);
    reqValid = 1'b0;
  endtask

  task automatic doSummary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R4 run did not end actual=hung expected=done");
    doSummary();
  end

  initial begin
    int e;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(!rspValid && !memReqValid, "R1 outputs idle", {rspValid, memReqValid}, 0);
    chk(accessCount == 0 && missCount == 0, "R1 counters zero", accessCount, 0);
    chk(!reqReady, "R1 no line resident", reqReady, 0);
    @(negedge clk);

    doAccess(16'h0123, e);
    chk(e == SETUP + BEATS + 1, "R4 miss penalty edges", e, SETUP + BEATS + 1);
    #2;
    chk(rspValid && rspData == sampleAt(16'h0123), "R6 stalled request data", rspData, sampleAt(16'h0123));
    @(negedge clk);

    for (int i = 0; i < 32; i++) begin
      doAccess(16'h0120 + ((i * 7) % 32), e);
      chk(e == 1, "R5 back-to-back hit", e, 1);
    end

    doAccess(16'h0323, e);
    chk(e == SETUP + BEATS + 1, "R2 same index other tag misses", e, SETUP + BEATS + 1);
    doAccess(16'h0123, e);
    chk(e == SETUP + BEATS + 1, "R2 evicted line misses", e, SETUP + BEATS + 1);
    doAccess(16'h0143, e);
    chk(e == SETUP + BEATS + 1, "R2 new index misses", e, SETUP + BEATS + 1);
    doAccess(16'h0123, e);
    chk(e == 1, "R2 other index kept", e, 1);

    for (int a = 16'h2000; a < 16'h2100; a += 3) doAccess(a, e);

    junk = 1'b1;
    repeat (6) @(negedge clk);
    junk = 1'b0;
    doAccess(16'h0130, e);
    chk(e == 1, "R10 stray beats keep line", e, 1);
    #2;
    chk(rspValid && rspData == sampleAt(16'h0130), "R10 data unchanged", rspData, sampleAt(16'h0130));
    @(negedge clk);

    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    doAccess(16'h0130, e);
    chk(e == SETUP + BEATS + 1, "R7 flushed line misses", e, SETUP + BEATS + 1);

    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    doAccess(16'h0130, e); doAccess(16'h0131, e); doAccess(16'h0132, e);
    doAccess(16'h3000, e); doAccess(16'h3001, e); doAccess(16'h3400, e);
    #2;
    chk(accessCount == 6, "R8 access count", accessCount, 6);
    chk(missCount == 2, "R8 miss count", missCount, 2);
    @(negedge clk);

    for (int i = 0; i < 300; i++) doAccess(16'h3400 + (i % 32), e);
    #2;
    chk(accessCount == MAXC, "R9 access saturates", accessCount, MAXC);
    chk(missCount == 2, "R9 miss unchanged", missCount, 2);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = 16'h3405;
    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    reqValid = 1'b0;
    #2;
    chk(accessCount == 0 && missCount == 0, "R9 clear beats increment", accessCount, 0);
    @(negedge clk);

    repeat (4) @(negedge clk);
    doSummary();
  end

endmodule